// File: doc/BRIEF.md
# Write-Protected Control Register Unit

This block keeps a small control register that configures a supervisory chip: a two-bit power-up delay select, a two-bit watchdog period select and a block-protect bit. A serial bus front end decodes the bus and hands the block one event per cycle: frame start, frame stop, a received byte (flagged when it is the device-select byte), a received register address, and a request for a read byte. The block answers each byte or address with an acknowledge decision one cycle later, supplies read data on a read request, and pulses a commit strobe whenever the retained bits change. The commit strobe stands in for a nonvolatile store cycle.

The retained bits are guarded by two volatile enable latches. A write of 02h raises the first latch. A later write of 06h, made while the first latch is up, raises the second latch. A third write, made while the second latch is up and with bit 2 of the data clear, loads the retained bits and drops the second latch. Each write frame carries a single data byte, and nothing takes effect until the STOP that closes the frame.

Top module: `ctlreg_unit`

## Requirements
- R1: A device-select byte is acknowledged only when its bits 7..4 are 1011. An address is acknowledged only in a selected frame and only when it equals 1FFh. A data byte is acknowledged only once both have matched in the current frame. Every byte or address event gives `ackValid` high for one cycle, with `ackOut` as the decision, on the cycle after the event.
- R2: Read data has the layout bit7 = delay select high bit, bit6..5 = watchdog select, bit4 = block protect, bit3 = 0 always, bit2 = second enable latch, bit1 = first enable latch, bit0 = delay select low bit. A 1 written to bit 3 is never read back.
- R3: Only the first data byte of a frame is acknowledged and kept. Later data bytes in the same frame are not acknowledged and have no effect.
- R4: A kept data byte acts only when STOP ends its frame. A new START before that STOP discards it.
- R5: A data byte of 02h sets the first latch. A data byte of 06h sets the second latch only if the first latch is already 1. Otherwise, 06h has no effect.
- R6: When the second latch is 1 and the data byte has bit 2 at 0, STOP loads bits 7, 6, 5, 4 and 0 into the retained bits, pulses `commitPulse` for one cycle on the cycle after STOP, and clears the second latch. The first latch stays 1.
- R7: A data byte that meets none of the R5 or R6 cases is acknowledged, but it changes no latch and no retained bit.
- R8: Reset clears both latches and loads the retained bits from parameter `RET_INIT`, which has the R2 layout. The default value is 00h.
- R9: A read request returns data (`rdValid` high, on the cycle after the request) only in a selected frame whose address pointer is 1FFh. The pointer survives a repeated START and is cleared by STOP. Each frame returns at most one byte.
- R10: The retained bits change only in the cycle in which `commitPulse` is high. Reads never change any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evStart | input | 1 | START or repeated START seen |
| evStop | input | 1 | STOP seen |
| evByte | input | 1 | A byte was received |
| byteIsSlave | input | 1 | Marks the received byte as the device-select byte |
| byteData | input | 8 | Received byte value |
| evAddr | input | 1 | A register address was received |
| regAddr | input | ADDR_W | Received register address |
| evRead | input | 1 | The bus wants a read byte |
| ackValid | output | 1 | Acknowledge decision valid |
| ackOut | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| rdValid | output | 1 | Read data valid |
| rdData | output | 8 | Register image |
| commitPulse | output | 1 | Retained bits updated (store cycle) |
| pupSel | output | 2 | Power-up delay select |
| wdSel | output | 2 | Watchdog period select |
| blkProt | output | 1 | Block protect |

## Verification
The state that matters is the two enable latches, the pending byte and the frame flags (selected, address matched, byte taken, read done).

A wrong frame flag shows at the acknowledge output one cycle after the next byte or address event. A latch that is set wrongly or stuck hides until the next register read, or until a STOP that should or should not commit. The bench therefore reads the register back after every write, so that such a fault shows up within one frame.

A per-cycle behavioural model compares every output on every clock. This catches a commit pulse or a retained-bit change in the wrong cycle at once.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  localparam int BYTE_W = 8;

  // Register image bit positions (read data layout)
  localparam int B_PUP1 = 7;
  localparam int B_WD1  = 6;
  localparam int B_WD0  = 5;
  localparam int B_BP   = 4;
  localparam int B_RSVD = 3;
  localparam int B_RWEL = 2;
  localparam int B_WEL  = 1;
  localparam int B_PUP0 = 0;

  typedef struct packed {
    logic loadPend;
    logic setWel;
    logic setRwel;
    logic commit;
    logic readOut;
  } ctlStrobe_t;

  typedef struct packed {
    logic pup1;
    logic wd1;
    logic wd0;
    logic bp;
    logic pup0;
  } retBits_t;

  function automatic retBits_t pickRet(input logic [BYTE_W-1:0] img);
    retBits_t r;
    r.pup1 = img[B_PUP1];
    r.wd1  = img[B_WD1];
    r.wd0  = img[B_WD0];
    r.bp   = img[B_BP];
    r.pup0 = img[B_PUP0];
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] packImage(input retBits_t r,
                                                  input logic rwel,
                                                  input logic wel);
    logic [BYTE_W-1:0] img;
    img         = '0;
    img[B_PUP1] = r.pup1;
    img[B_WD1]  = r.wd1;
    img[B_WD0]  = r.wd0;
    img[B_BP]   = r.bp;
    img[B_RSVD] = 1'b0;
    img[B_RWEL] = rwel;
    img[B_WEL]  = wel;
    img[B_PUP0] = r.pup0;
    return img;
  endfunction
endpackage

// File: rtl/ctlreg_ctrl.sv
module ctlreg_ctrl
  import ctlreg_pkg::*;
#(
  parameter int              ADDR_W   = 9,
  parameter logic [ADDR_W-1:0] REG_ADDR = 9'h1FF,
  parameter logic [3:0]      PREAMBLE = 4'b1011,
  parameter logic [BYTE_W-1:0] WEL_KEY  = 8'h02,
  parameter logic [BYTE_W-1:0] RWEL_KEY = 8'h06
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evStart,
  input  logic              evStop,
  input  logic              evByte,
  input  logic              byteIsSlave,
  input  logic [3:0]        slaveHi,
  input  logic              evAddr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              evRead,
  input  logic              welQ,
  input  logic              rwelQ,
  input  logic [BYTE_W-1:0] pendByte,
  output ctlStrobe_t        strobe,
  output logic              ackValid,
  output logic              ackOut
);
  logic selected;     // device-select matched in this frame
  logic ptrHit;       // address pointer at the register (survives repeated START)
  logic addrInFrame;  // address matched inside this frame
  logic dataTaken;    // one data byte already kept
  logic readDone;     // one read byte already returned

  logic slaveMatch, addrMatch, slaveEv, dataEv, ackNext;
  logic stopWithData;

  assign slaveMatch   = (slaveHi == PREAMBLE);
  assign addrMatch    = (regAddr == REG_ADDR);
  assign slaveEv      = evByte && byteIsSlave;
  assign dataEv       = evByte && !byteIsSlave;
  assign stopWithData = evStop && dataTaken;

  always_comb begin
    strobe          = '0;
    strobe.loadPend = dataEv && selected && addrInFrame && !dataTaken;
    strobe.readOut  = evRead && selected && ptrHit && !readDone;
    strobe.commit   = stopWithData && rwelQ && !pendByte[B_RWEL];
    strobe.setWel   = stopWithData && !strobe.commit && (pendByte == WEL_KEY);
    strobe.setRwel  = stopWithData && !strobe.commit && welQ &&
                      (pendByte == RWEL_KEY);
  end

  always_comb begin
    ackNext = 1'b0;
    if (evAddr)       ackNext = selected && addrMatch;
    else if (slaveEv) ackNext = slaveMatch;
    else if (dataEv)  ackNext = strobe.loadPend;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selected    <= 1'b0;
      ptrHit      <= 1'b0;
      addrInFrame <= 1'b0;
      dataTaken   <= 1'b0;
      readDone    <= 1'b0;
      ackValid    <= 1'b0;
      ackOut      <= 1'b0;
    end else begin
      ackValid <= evByte || evAddr;
      ackOut   <= ackNext;
      if (evStart) begin
        selected    <= 1'b0;
        addrInFrame <= 1'b0;
        dataTaken   <= 1'b0;
        readDone    <= 1'b0;
      end else if (evStop) begin
        selected    <= 1'b0;
        ptrHit      <= 1'b0;
        addrInFrame <= 1'b0;
        dataTaken   <= 1'b0;
        readDone    <= 1'b0;
      end else begin
        if (slaveEv) selected <= slaveMatch;
        if (evAddr && selected) begin
          ptrHit      <= addrMatch;
          addrInFrame <= addrMatch;
        end
        if (strobe.loadPend) dataTaken <= 1'b1;
        if (strobe.readOut)  readDone  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ctlreg_dp.sv
module ctlreg_dp
  import ctlreg_pkg::*;
#(
  parameter logic [BYTE_W-1:0] RET_INIT = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [BYTE_W-1:0] byteData,
  output logic              welQ,
  output logic              rwelQ,
  output logic [BYTE_W-1:0] pendByte,
  output retBits_t          retBits,
  output logic              rdValid,
  output logic [BYTE_W-1:0] rdData,
  output logic              commitPulse
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      welQ        <= 1'b0;
      rwelQ       <= 1'b0;
      pendByte    <= '0;
      retBits     <= pickRet(RET_INIT);
      rdValid     <= 1'b0;
      rdData      <= '0;
      commitPulse <= 1'b0;
    end else begin
      commitPulse <= strobe.commit;
      rdValid     <= strobe.readOut;
      if (strobe.readOut)  rdData   <= packImage(retBits, rwelQ, welQ);
      if (strobe.loadPend) pendByte <= byteData;
      if (strobe.setWel)   welQ     <= 1'b1;
      if (strobe.setRwel)  rwelQ    <= 1'b1;
      if (strobe.commit) begin
        retBits <= pickRet(pendByte);
        rwelQ   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ctlreg_unit.sv
module ctlreg_unit
  import ctlreg_pkg::*;
#(
  parameter int                ADDR_W   = 9,
  parameter logic [ADDR_W-1:0] REG_ADDR = 9'h1FF,
  parameter logic [3:0]        PREAMBLE = 4'b1011,
  parameter logic [7:0]        WEL_KEY  = 8'h02,
  parameter logic [7:0]        RWEL_KEY = 8'h06,
  parameter logic [7:0]        RET_INIT = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evStart,
  input  logic              evStop,
  input  logic              evByte,
  input  logic              byteIsSlave,
  input  logic [7:0]        byteData,
  input  logic              evAddr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              evRead,
  output logic              ackValid,
  output logic              ackOut,
  output logic              rdValid,
  output logic [7:0]        rdData,
  output logic              commitPulse,
  output logic [1:0]        pupSel,
  output logic [1:0]        wdSel,
  output logic              blkProt
);
  ctlStrobe_t        strobe;
  logic              welQ, rwelQ;
  logic [BYTE_W-1:0] pendByte;
  retBits_t          retBits;

  ctlreg_ctrl #(
    .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .PREAMBLE(PREAMBLE),
    .WEL_KEY(WEL_KEY), .RWEL_KEY(RWEL_KEY)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .evStart(evStart), .evStop(evStop),
    .evByte(evByte), .byteIsSlave(byteIsSlave), .slaveHi(byteData[7:4]),
    .evAddr(evAddr), .regAddr(regAddr), .evRead(evRead),
    .welQ(welQ), .rwelQ(rwelQ), .pendByte(pendByte),
    .strobe(strobe), .ackValid(ackValid), .ackOut(ackOut)
  );

  ctlreg_dp #(.RET_INIT(RET_INIT)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .byteData(byteData),
    .welQ(welQ), .rwelQ(rwelQ), .pendByte(pendByte), .retBits(retBits),
    .rdValid(rdValid), .rdData(rdData), .commitPulse(commitPulse)
  );

  assign pupSel  = {retBits.pup1, retBits.pup0};
  assign wdSel   = {retBits.wd1, retBits.wd0};
  assign blkProt = retBits.bp;
endmodule

// File: rtl/ctlreg_chk.sv
module ctlreg_chk (
  input logic       clk,
  input logic       rstN,
  input logic       evStart,
  input logic       evStop,
  input logic       evByte,
  input logic       evAddr,
  input logic       evRead,
  input logic       commitPulse,
  input logic       rdValid,
  input logic       rsvdBit,
  input logic       welQ,
  input logic       rwelQ,
  input logic [4:0] retImg
);
  // input contract: one bus event per cycle
  p_one_event_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({evStart, evStop, evByte, evAddr, evRead}));

  p_commit_on_stop_r4: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |-> $past(evStop));

  p_commit_needs_rwel_r6: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |-> $past(rwelQ));

  p_rwel_cleared_r6: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |-> (!rwelQ && welQ));

  p_rwel_needs_wel_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rwelQ) |-> $past(welQ));

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !rsvdBit);

  p_retained_only_commit_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(retImg) |-> commitPulse);

  p_read_after_request_r9: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(evRead));
endmodule

bind ctlreg_unit ctlreg_chk i_chk (
  .clk(clk), .rstN(rstN), .evStart(evStart), .evStop(evStop),
  .evByte(evByte), .evAddr(evAddr), .evRead(evRead),
  .commitPulse(commitPulse), .rdValid(rdValid), .rsvdBit(rdData[3]),
  .welQ(welQ), .rwelQ(rwelQ), .retImg(retBits)
);

// File: tb/test_ctlreg_unit.sv
`timescale 1ns/1ps
module test_ctlreg_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       evStart = 0, evStop = 0, evByte = 0, byteIsSlave = 0;
  logic       evAddr = 0, evRead = 0;
  logic [7:0] byteData = '0;
  logic [8:0] regAddr = '0;
  logic       ackValid, ackOut, rdValid, commitPulse, blkProt;
  logic [7:0] rdData;
  logic [1:0] pupSel, wdSel;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  ctlreg_unit i_ctlreg_unit (
    .clk(clk), .rstN(rstN), .evStart(evStart), .evStop(evStop),
    .evByte(evByte), .byteIsSlave(byteIsSlave), .byteData(byteData),
    .evAddr(evAddr), .regAddr(regAddr), .evRead(evRead),
    .ackValid(ackValid), .ackOut(ackOut), .rdValid(rdValid),
    .rdData(rdData), .commitPulse(commitPulse), .pupSel(pupSel),
    .wdSel(wdSel), .blkProt(blkProt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit       mSel, mPtr, mAddrF, mTaken, mRdDone, mWel, mRwel;
  bit [7:0] mPend, mRet, mRdD;
  bit       mAckV, mAck, mRdV, mCommit;

  always @(posedge clk) begin
    if (!rstN) begin
      {mSel, mPtr, mAddrF, mTaken, mRdDone, mWel, mRwel} = '0;
      mPend = 0; mRet = 8'h00; mRdD = 0;
      {mAckV, mAck, mRdV, mCommit} = '0;
    end else begin
      mAckV = evByte | evAddr; mAck = 0; mRdV = 0; mCommit = 0;
      if (evStart) begin
        mSel = 0; mAddrF = 0; mTaken = 0; mRdDone = 0;
      end else if (evStop) begin
        if (mTaken) begin
          if (mRwel && !mPend[2]) begin
            mRet = mPend & 8'hF1; mRwel = 0; mCommit = 1;
          end else if (mPend == 8'h02) mWel = 1;
          else if (mPend == 8'h06 && mWel) mRwel = 1;
        end
        mSel = 0; mPtr = 0; mAddrF = 0; mTaken = 0; mRdDone = 0;
      end else if (evByte && byteIsSlave) begin
        mSel = (byteData[7:4] == 4'hB); mAck = mSel;
      end else if (evAddr) begin
        if (mSel) begin mPtr = (regAddr == 9'h1FF); mAddrF = mPtr; mAck = mPtr; end
      end else if (evByte) begin
        if (mSel && mAddrF && !mTaken) begin mPend = byteData; mTaken = 1; mAck = 1; end
      end else if (evRead) begin
        if (mSel && mPtr && !mRdDone) begin
          mRdV = 1; mRdDone = 1;
          mRdD = mRet | (8'(mRwel) << 2) | (8'(mWel) << 1);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      chk({ackValid, ackOut} == {mAckV, mAck}, "R1/R3 ack", {ackValid, ackOut}, {mAckV, mAck});
      chk({rdValid, rdData} == {mRdV, mRdD}, "R2/R9 read", {rdValid, rdData}, {mRdV, mRdD});
      chk(commitPulse == mCommit, "R4/R6 commit", commitPulse, mCommit);
      chk({pupSel, wdSel, blkProt} == {mRet[7], mRet[0], mRet[6:5], mRet[4]},
          "R10 retained", {pupSel, wdSel, blkProt}, {mRet[7], mRet[0], mRet[6:5], mRet[4]});
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- stimulus tasks (entered at a negedge) ----------------
  task automatic tStart; evStart = 1; @(negedge clk); evStart = 0; endtask
  task automatic tStop;  evStop = 1;  @(negedge clk); evStop = 0;  endtask
  task automatic tRead;  evRead = 1;  @(negedge clk); evRead = 0;  endtask
  task automatic tSlave(input logic [7:0] b);
    evByte = 1; byteIsSlave = 1; byteData = b; @(negedge clk); evByte = 0; byteIsSlave = 0;
  endtask
  task automatic tData(input logic [7:0] b);
    evByte = 1; byteData = b; @(negedge clk); evByte = 0;
  endtask
  task automatic tAddr(input logic [8:0] a);
    evAddr = 1; regAddr = a; @(negedge clk); evAddr = 0;
  endtask

  task automatic writeReg(input logic [7:0] d);
    tStart; tSlave(8'hB0); tAddr(9'h1FF); tData(d); tStop;
  endtask

  task automatic readReg(output logic v, output logic [7:0] d);
    tStart; tSlave(8'hB0); tAddr(9'h1FF); tStart; tSlave(8'hB1); tRead;
    v = rdValid; d = rdData; tStop;
  endtask

  task automatic expectRead(input logic [7:0] e, input string req);
    logic v; logic [7:0] d;
    readReg(v, d);
    chk(v && d == e, req, {v, d}, {1'b1, e});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({pupSel, wdSel, blkProt} == 5'b0, "R8 reset outputs", {pupSel, wdSel, blkProt}, 0);
    rstN = 1;
    @(negedge clk);
    expectRead(8'h00, "R8 reset image");

    // R1: wrong preamble, then wrong address
    tStart; tSlave(8'hA0); chk(ackValid && !ackOut, "R1 bad preamble", ackOut, 0);
    tAddr(9'h1FF); chk(!ackOut, "R1 addr unselected", ackOut, 0);
    tData(8'h02); chk(!ackOut, "R1 data unselected", ackOut, 0);
    tStop;
    tStart; tSlave(8'hB0); chk(ackOut, "R1 good preamble", ackOut, 1);
    tAddr(9'h0FF); chk(!ackOut, "R1 wrong address", ackOut, 0);
    tData(8'h02); chk(!ackOut, "R1 data wrong address", ackOut, 0);
    tStop;
    expectRead(8'h00, "R1 nothing written");

    // R5: enable sequence
    writeReg(8'h06); expectRead(8'h00, "R5 06h without first latch");
    writeReg(8'h02); expectRead(8'h02, "R5 first latch");
    writeReg(8'h06); expectRead(8'h06, "R5 second latch");

    // R6 / R2: commit, reserved bit written 1
    writeReg(8'hF9);
    chk(commitPulse, "R6 commit pulse", commitPulse, 1);
    chk({pupSel, wdSel, blkProt} == 5'b11111, "R6 retained loaded", {pupSel, wdSel, blkProt}, 5'h1F);
    expectRead(8'hF3, "R2 R6 image after commit");

    // R7: write without enable
    tStart; tSlave(8'hB0); tAddr(9'h1FF); tData(8'h50);
    chk(ackOut, "R7 unenabled data acked", ackOut, 1);
    tStop; chk(!commitPulse, "R7 no commit", commitPulse, 0);
    expectRead(8'hF3, "R7 unchanged");

    // R3: extra data bytes
    writeReg(8'h06); expectRead(8'hF7, "R5 second latch again");
    tStart; tSlave(8'hB0); tAddr(9'h1FF); tData(8'h00);
    chk(ackOut, "R3 first byte acked", ackOut, 1);
    tData(8'hFF); chk(ackValid && !ackOut, "R3 second byte nacked", ackOut, 0);
    tStop; chk(commitPulse, "R3 first byte committed", commitPulse, 1);
    expectRead(8'h02, "R3 R6 image");

    // R4: repeated START discards the pending byte
    writeReg(8'h06);
    tStart; tSlave(8'hB0); tAddr(9'h1FF); tData(8'h10); tStart; tStop;
    chk(!commitPulse, "R4 aborted by START", commitPulse, 0);
    expectRead(8'h06, "R4 state kept");
    writeReg(8'h10); chk(blkProt, "R4 commit on STOP", blkProt, 1);
    expectRead(8'h12, "R4 image");

    // R9: read without pointer, second read in frame
    tStart; tSlave(8'hB1); tRead;
    chk(!rdValid, "R9 no pointer", rdValid, 0);
    tStop;
    tStart; tSlave(8'hB0); tAddr(9'h1FF); tStart; tSlave(8'hB1); tRead;
    chk(rdValid && rdData == 8'h12, "R9 first read", rdData, 8'h12);
    tRead; chk(!rdValid, "R9 second read none", rdValid, 0);
    tStop;
    expectRead(8'h12, "R10 reads change nothing");

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule